// File: doc/BRIEF.md
# Splittable Dual 32-bit Timer

This peripheral is a 64-bit count-up timer with a 32-bit register port. A mode field in the global control register selects its shape. In split mode it acts as two independent 32-bit halves, lower and upper. Each half has its own counter, period, enable mode and interrupt line. In wide mode the two words form one 64-bit counter, controlled by the lower half's enable field and signalled on the lower interrupt.

Each half is run by a small state machine with four states:

- `ST_HOLD`: the half's release bit is 0. The counter is forced to zero and the half cannot fire.
- `ST_IDLE`: released but disabled. The counter keeps its value.
- `ST_SINGLE`: one-shot counting.
- `ST_REPEAT`: periodic counting.

The transitions are:

- **release drop**: any state goes to `ST_HOLD` when its release bit is 0.
- **release rise**: `ST_HOLD` goes to `ST_IDLE`.
- **mode write**: from any released state, a control-register write moves the half to the state its field encodes.
- **one-shot finish**: `ST_SINGLE` goes to `ST_IDLE` on a period match.

A match in `ST_REPEAT` keeps the state and clears the counter. Software writes periods and counters directly. A period of all ones turns a half into a free-running counter.

Top module: `split_timer`

## Requirements
- R1: After reset every register reads 0 except the identity word, and both interrupt outputs are low.
- R2: Reading offset 0x00 returns the parameter `ID_WORD` (default 0x54490102). Offset 0x28 is reserved: it reads 0 and ignores writes.
- R3: In periodic mode (field value 2) a running half counts up by one per clock. The first clock edge after the counter equals the period resets it to 0. The half's interrupt is high for exactly the following cycle.
- R4: In one-shot mode (field value 1) a match holds the counter at the period value and sets the field back to 0. The interrupt is high for one cycle.
- R5: The enable fields sit at control bits 7:6 (lower) and 23:22 (upper). The value 0 disables the half, and so does the reserved value 3. A disabled half keeps its counter value.
- R6: Software writes the lower counter at 0x10 and the upper counter at 0x14; the periods sit at 0x18 and 0x1C. A counter write takes effect at the next edge and overrides counting.
- R7: With a period of 0xFFFFFFFF a periodic half steps from 0xFFFFFFFF to 0 and pulses its interrupt.
- R8: Global control at 0x24 holds the timer mode in bits 3:2, the lower release in bit 0 and the upper release in bit 1. While a release bit is 0, that counter is held at 0, its field reads 0, control and counter writes to it are ignored, and its interrupt stays low.
- R9: Timer mode 0 joins the words: lower is the low word, upper the high word, with a carry between them. The match compares all 64 bits. Only the lower field and `irq_lo` are used, and `irq_hi` stays low.
- R10: Timer modes 2 and 3 are stored and read back, but neither counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_lo | output | 1 | Lower half (or 64-bit) match pulse |
| irq_hi | output | 1 | Upper half match pulse |

## Verification
A register write lands on the clock edge after the strobe. A counter starts moving on the first edge after its enable field is written. A match changes the counter on the edge that sees equality, and the interrupt is high during the cycle after that same edge. The vector table states, for each read, how many whole cycles to wait after the previous step. Reads and interrupt samples are taken at the falling edge, half a cycle after the registers settle. Each expected value is derived by counting edges from the last write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        EN_OFF    = 2'd0,
        EN_SINGLE = 2'd1,
        EN_REPEAT = 2'd2,
        EN_RSVD   = 2'd3
    } en_mode_e;

    typedef enum logic [1:0] {
        TM_WIDE  = 2'd0,
        TM_SPLIT = 2'd1,
        TM_WDOG  = 2'd2,
        TM_CHAIN = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_IDLE,
        ST_SINGLE,
        ST_REPEAT
    } half_st_e;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_PRD_LO = 8'h18;
    localparam logic [7:0] OFS_PRD_HI = 8'h1C;
    localparam logic [7:0] OFS_CTRL   = 8'h20;
    localparam logic [7:0] OFS_GCTRL  = 8'h24;
    localparam logic [7:0] OFS_WDOG   = 8'h28;

    localparam int FLD_LO_POS = 6;
    localparam int FLD_HI_POS = 22;
endpackage

// File: rtl/tmr_half_fsm.sv
module tmr_half_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       release_i,
    input  logic       cnt_ok_i,
    input  logic       mode_we_i,
    input  logic [1:0] mode_wd_i,
    input  logic       hit_i,
    output logic       adv_o,
    output logic       wrap_o,
    output logic       irq_o,
    output logic [1:0] field_o
);
    half_st_e state_q, state_d;
    logic     running;
    logic     fire;

    always_comb begin
        state_d = state_q;
        if (!release_i) begin
            state_d = ST_HOLD;
        end else if (mode_we_i) begin
            unique case (en_mode_e'(mode_wd_i))
                EN_SINGLE: state_d = ST_SINGLE;
                EN_REPEAT: state_d = ST_REPEAT;
                default:   state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_HOLD:   state_d = ST_IDLE;
                ST_SINGLE: if (fire) state_d = ST_IDLE;
                default:   state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        running = 1'b0;
        field_o = EN_OFF;
        unique case (state_q)
            ST_SINGLE: begin running = 1'b1; field_o = EN_SINGLE; end
            ST_REPEAT: begin running = 1'b1; field_o = EN_REPEAT; end
            default:   begin running = 1'b0; field_o = EN_OFF;    end
        endcase
        adv_o  = running && cnt_ok_i && release_i;
        fire   = adv_o && hit_i;
        wrap_o = fire && (state_q == ST_REPEAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= fire;
    end

    // R4: a one-shot match with no competing write ends in the idle state
    a_r4_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SINGLE && hit_i && cnt_ok_i && release_i && !mode_we_i)
        |=> (state_q == ST_IDLE && field_o == 2'd0));

    // R8: a held half cannot raise its interrupt on the next cycle
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !irq_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_i,
    input  logic          rel_lo_i,
    input  logic          rel_hi_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          adv_lo_i,
    input  logic          adv_hi_i,
    input  logic          wrap_lo_i,
    input  logic          wrap_hi_i,
    input  logic [DW-1:0] prd_lo_i,
    input  logic [DW-1:0] prd_hi_i,
    output logic [DW-1:0] cnt_lo_o,
    output logic [DW-1:0] cnt_hi_o,
    output logic          hit_lo_o,
    output logic          hit_hi_o
);
    localparam int FW = 2 * DW;

    logic          lo_full;
    logic          carry;
    logic          inc_hi;
    logic          clr_hi;

    assign lo_full  = &cnt_lo_o;
    assign hit_lo_o = wide_i ? ({cnt_hi_o, cnt_lo_o} == FW'({prd_hi_i, prd_lo_i}))
                             : (cnt_lo_o == prd_lo_i);
    assign hit_hi_o = !wide_i && (cnt_hi_o == prd_hi_i);
    assign carry    = wide_i && adv_lo_i && !hit_lo_o && lo_full;
    assign inc_hi   = wide_i ? carry : (adv_hi_i && !hit_hi_o);
    assign clr_hi   = wide_i ? wrap_lo_i : wrap_hi_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_lo_o <= '0;
        else if (!rel_lo_i)              cnt_lo_o <= '0;
        else if (wr_lo_i)                cnt_lo_o <= wdata_i;
        else if (wrap_lo_i)              cnt_lo_o <= '0;
        else if (adv_lo_i && !hit_lo_o)  cnt_lo_o <= cnt_lo_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_hi_o <= '0;
        else if (!rel_hi_i) cnt_hi_o <= '0;
        else if (wr_hi_i)   cnt_hi_o <= wdata_i;
        else if (clr_hi)    cnt_hi_o <= '0;
        else if (inc_hi)    cnt_hi_o <= cnt_hi_o + 1'b1;
    end

    // R8: a word whose release bit is low reads zero one edge later
    a_r8_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_lo_i |=> (cnt_lo_o == '0));

    // R3: a periodic match returns the counter to zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_lo_i && !wr_lo_i && rel_lo_i) |=> (cnt_lo_o == '0));

    // R5: a stopped, released, unwritten counter keeps its value
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_lo_i && !wr_lo_i && !adv_lo_i && !wrap_lo_i) |=> $stable(cnt_lo_o));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int          AW      = 8,
    parameter int          DW      = 32,
    parameter logic [31:0] ID_WORD = 32'h5449_0102
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] prd_lo_o,
    output logic [DW-1:0] prd_hi_o,
    output tmode_e        tmode_o,
    output logic [1:0]    rel_o,
    output logic          wr_cnt_lo_o,
    output logic          wr_cnt_hi_o,
    output logic          mode_we_o,
    input  logic [DW-1:0] cnt_lo_i,
    input  logic [DW-1:0] cnt_hi_i,
    input  logic [1:0]    field_lo_i,
    input  logic [1:0]    field_hi_i
);
    assign wr_cnt_lo_o = wr_i && (addr_i == AW'(OFS_CNT_LO));
    assign wr_cnt_hi_o = wr_i && (addr_i == AW'(OFS_CNT_HI));
    assign mode_we_o   = wr_i && (addr_i == AW'(OFS_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_lo_o <= '0;
            prd_hi_o <= '0;
            tmode_o  <= TM_WIDE;
            rel_o    <= 2'b00;
        end else if (wr_i) begin
            if (addr_i == AW'(OFS_PRD_LO)) prd_lo_o <= wdata_i;
            if (addr_i == AW'(OFS_PRD_HI)) prd_hi_o <= wdata_i;
            if (addr_i == AW'(OFS_GCTRL)) begin
                tmode_o <= tmode_e'(wdata_i[3:2]);
                rel_o   <= wdata_i[1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            AW'(OFS_ID):     rdata_o = DW'(ID_WORD);
            AW'(OFS_CNT_LO): rdata_o = cnt_lo_i;
            AW'(OFS_CNT_HI): rdata_o = cnt_hi_i;
            AW'(OFS_PRD_LO): rdata_o = prd_lo_o;
            AW'(OFS_PRD_HI): rdata_o = prd_hi_o;
            AW'(OFS_CTRL): begin
                rdata_o[FLD_LO_POS +: 2] = field_lo_i;
                rdata_o[FLD_HI_POS +: 2] = field_hi_i;
            end
            AW'(OFS_GCTRL):  rdata_o[3:0] = {tmode_o, rel_o};
            default:         rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/split_timer.sv
module split_timer
    import tmr_pkg::*;
#(
    parameter int          AW      = 8,
    parameter int          DW      = 32,
    parameter logic [31:0] ID_WORD = 32'h5449_0102
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_lo,
    output logic          irq_hi
);
    localparam int NH = 2;

    logic [DW-1:0] prd_lo, prd_hi, cnt_lo, cnt_hi;
    tmode_e        tmode;
    logic [NH-1:0] rel, cnt_ok, hit, adv, wrap, irq;
    logic [1:0]    field [NH];
    logic          wr_cnt_lo, wr_cnt_hi, mode_we;
    logic          wide, split;

    assign wide      = (tmode == TM_WIDE);
    assign split     = (tmode == TM_SPLIT);
    assign cnt_ok[0] = wide || split;
    assign cnt_ok[1] = split;

    tmr_regs #(.AW(AW), .DW(DW), .ID_WORD(ID_WORD)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (reg_addr),
        .wr_i        (reg_wr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .prd_lo_o    (prd_lo),
        .prd_hi_o    (prd_hi),
        .tmode_o     (tmode),
        .rel_o       (rel),
        .wr_cnt_lo_o (wr_cnt_lo),
        .wr_cnt_hi_o (wr_cnt_hi),
        .mode_we_o   (mode_we),
        .cnt_lo_i    (cnt_lo),
        .cnt_hi_i    (cnt_hi),
        .field_lo_i  (field[0]),
        .field_hi_i  (field[1])
    );

    for (genvar gi = 0; gi < NH; gi++) begin : g_half
        localparam int POS = (gi == 0) ? FLD_LO_POS : FLD_HI_POS;
        tmr_half_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .release_i (rel[gi]),
            .cnt_ok_i  (cnt_ok[gi]),
            .mode_we_i (mode_we),
            .mode_wd_i (reg_wdata[POS +: 2]),
            .hit_i     (hit[gi]),
            .adv_o     (adv[gi]),
            .wrap_o    (wrap[gi]),
            .irq_o     (irq[gi]),
            .field_o   (field[gi])
        );
    end

    tmr_count #(.DW(DW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_i    (wide),
        .rel_lo_i  (rel[0]),
        .rel_hi_i  (rel[1]),
        .wr_lo_i   (wr_cnt_lo),
        .wr_hi_i   (wr_cnt_hi),
        .wdata_i   (reg_wdata),
        .adv_lo_i  (adv[0]),
        .adv_hi_i  (adv[1]),
        .wrap_lo_i (wrap[0]),
        .wrap_hi_i (wrap[1]),
        .prd_lo_i  (prd_lo),
        .prd_hi_i  (prd_hi),
        .cnt_lo_o  (cnt_lo),
        .cnt_hi_o  (cnt_hi),
        .hit_lo_o  (hit[0]),
        .hit_hi_o  (hit[1])
    );

    assign irq_lo = irq[0];
    assign irq_hi = irq[1];

    // R9: in the joined mode the upper interrupt never fires
    a_r9_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !irq_hi);

    // R10: reserved timer modes freeze both counters unless software writes them
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !split && !wr_cnt_lo && rel[0]) |=> $stable(cnt_lo));
endmodule

// File: tb/sim_split_timer.sv
module sim_split_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] ID_EXP = 32'h5449_0102;
    localparam int NSTEP = 58;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    split_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    // step word: wr[50] idle[49:46] addr[45:38] data[37:6] irq{hi,lo}[5:4] req[3:0]
    function automatic logic [50:0] st(input logic w, input logic [3:0] idle,
                                       input logic [7:0] a, input logic [31:0] d,
                                       input logic [1:0] q, input logic [3:0] r);
        return {w, idle, a, d, q, r};
    endfunction

    localparam logic [50:0] TBL [NSTEP] = '{
        st(0, 0, 8'h00, ID_EXP,       2'b00, 2),   // R2 identity
        st(0, 0, 8'h24, 32'h0,        2'b00, 1),   // R1 global control
        st(0, 0, 8'h20, 32'h0,        2'b00, 1),   // R1 control
        st(0, 0, 8'h10, 32'h0,        2'b00, 1),   // R1 counter
        st(1, 0, 8'h24, 32'h7,        2'b00, 8),
        st(1, 0, 8'h18, 32'h3,        2'b00, 6),
        st(1, 0, 8'h1C, 32'h5,        2'b00, 6),
        st(1, 0, 8'h20, 32'h0040_0080, 2'b00, 5),
        st(0, 0, 8'h10, 32'h0,        2'b00, 3),   // R3
        st(0, 3, 8'h10, 32'h3,        2'b00, 3),
        st(0, 1, 8'h10, 32'h0,        2'b01, 3),   // R3 wrap + pulse
        st(0, 0, 8'h14, 32'h4,        2'b01, 4),   // R4
        st(0, 1, 8'h14, 32'h5,        2'b00, 4),
        st(0, 1, 8'h14, 32'h5,        2'b10, 4),   // R4 one-shot pulse
        st(0, 0, 8'h20, 32'h0000_0080, 2'b10, 4),  // R4 field cleared
        st(0, 2, 8'h10, 32'h0,        2'b01, 3),
        st(1, 0, 8'h20, 32'h0,        2'b00, 5),
        st(0, 0, 8'h10, 32'h1,        2'b00, 5),   // R5 disabled holds
        st(0, 3, 8'h10, 32'h1,        2'b00, 5),
        st(1, 0, 8'h10, 32'hFFFF_FFFE, 2'b00, 6),
        st(1, 0, 8'h18, 32'hFFFF_FFFF, 2'b00, 7),
        st(1, 0, 8'h20, 32'h0000_0080, 2'b00, 7),
        st(0, 0, 8'h10, 32'hFFFF_FFFE, 2'b00, 6),  // R6 written value
        st(0, 1, 8'h10, 32'hFFFF_FFFF, 2'b00, 7),  // R7
        st(0, 1, 8'h10, 32'h0,        2'b01, 7),   // R7 wrap pulse
        st(1, 0, 8'h24, 32'h6,        2'b00, 8),
        st(0, 1, 8'h10, 32'h0,        2'b00, 8),   // R8 held at zero
        st(0, 0, 8'h20, 32'h0,        2'b00, 8),
        st(1, 0, 8'h20, 32'h0000_0080, 2'b00, 8),
        st(0, 0, 8'h20, 32'h0,        2'b00, 8),   // R8 mode write ignored
        st(1, 0, 8'h10, 32'h9,        2'b00, 8),
        st(0, 0, 8'h10, 32'h0,        2'b00, 8),   // R8 counter write ignored
        st(1, 0, 8'h24, 32'h7,        2'b00, 8),
        st(0, 1, 8'h20, 32'h0,        2'b00, 8),
        st(1, 0, 8'h24, 32'h3,        2'b00, 9),
        st(1, 0, 8'h10, 32'hFFFF_FFFD, 2'b00, 9),
        st(1, 0, 8'h14, 32'h0,        2'b00, 9),
        st(1, 0, 8'h18, 32'h1,        2'b00, 9),
        st(1, 0, 8'h1C, 32'h1,        2'b00, 9),
        st(1, 0, 8'h20, 32'h0040_0040, 2'b00, 9),
        st(0, 2, 8'h10, 32'hFFFF_FFFF, 2'b00, 9),  // R9
        st(0, 0, 8'h14, 32'h0,        2'b00, 9),
        st(0, 1, 8'h14, 32'h1,        2'b00, 9),   // R9 carry
        st(0, 0, 8'h10, 32'h0,        2'b00, 9),
        st(0, 1, 8'h10, 32'h1,        2'b00, 9),
        st(0, 1, 8'h10, 32'h1,        2'b01, 9),   // R9 64-bit match
        st(0, 0, 8'h14, 32'h1,        2'b01, 9),
        st(0, 1, 8'h20, 32'h0040_0000, 2'b00, 9),
        st(1, 0, 8'h24, 32'hB,        2'b00, 10),
        st(1, 0, 8'h20, 32'h0000_0080, 2'b00, 10),
        st(0, 3, 8'h10, 32'h1,        2'b00, 10),  // R10 frozen
        st(0, 0, 8'h24, 32'hB,        2'b00, 10),
        st(1, 0, 8'h28, 32'hFFFF_FFFF, 2'b00, 2),
        st(0, 0, 8'h28, 32'h0,        2'b00, 2),   // R2 reserved reads 0
        st(1, 0, 8'h20, 32'h0000_00C0, 2'b00, 5),
        st(1, 0, 8'h24, 32'h7,        2'b00, 5),
        st(0, 1, 8'h10, 32'h1,        2'b00, 5),   // R5 code 3 disables
        st(0, 0, 8'h20, 32'h0,        2'b00, 5)
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, $sformatf("read 0x%02h", a), reg_rdata, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "irq after reset", {30'd0, irq_hi, irq_lo}, 32'd0);

        for (int i = 0; i < NSTEP; i++) begin
            logic [50:0] s;
            s = TBL[i];
            repeat (int'(s[49:46])) @(negedge clk);
            if (s[50]) begin
                wr(s[45:38], s[37:6]);
            end else begin
                rd_check(int'(s[3:0]), s[45:38], s[37:6]);
                check(int'(s[3:0]), "irq {hi,lo}", {30'd0, irq_hi, irq_lo}, {30'd0, s[5:4]});
            end
        end

        // R6: counter write overrides counting in a running half
        wr(8'h18, 32'h100);
        wr(8'h20, 32'h0000_0080);
        repeat (2) @(negedge clk);
        wr(8'h10, 32'h40);
        rd_check(6, 8'h10, 32'h40);

        // R1: reset in the middle of a run clears everything at once
        rst_n = 1'b0;
        #1;
        rd_check(1, 8'h10, 32'h0);
        rd_check(1, 8'h18, 32'h0);
        rd_check(1, 8'h20, 32'h0);
        rd_check(1, 8'h24, 32'h0);
        rd_check(2, 8'h00, ID_EXP);
        check(1, "irq in reset", {30'd0, irq_hi, irq_lo}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_check(1, 8'h10, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule